// File: doc/BRIEF.md
# Masked Interrupt Controller with Delayed IRQ

The block gathers single-cycle event pulses from several sources, two timer underflows among them, into a sticky pending-status register. It compares the pending bits against an enable mask and drives an active-high interrupt request through one register stage, so a masked-in event shows on `irq_o` right after the clock edge that samples it.

A host changes the mask with set/clear writes. A written value first lands in a shadow register and reaches the active mask one edge later. The host reads status through a combinational read port, and the read clears everything at the closing edge. One source index is the Timer B underflow, and it has a special rule. If its pulse arrives in the very cycle of a status read, the pulse is dropped rather than left pending. A Timer B pulse that arrives one cycle before the read is still reported normally.

Top module: `icr_irq_ctrl`

## Requirements
- R1: After reset, the pending bits, the shadow mask and the active mask are all zero, and `irq_o` is low.
- R2: A pulse on `evt_i[k]` sets pending bit k at the sampling edge. `rd_data_o` always shows the pending bits in bits NUM_SRC-1:0, `irq_o` in bit 7, and zeros in the remaining bits.
- R3: A pulse on a source whose active mask bit is set raises `irq_o` immediately after the edge that samples the pulse. The latency is one cycle.
- R4: Once raised, `irq_o` stays high until a status read. Pending bits whose mask bit is clear never raise `irq_o`, and `irq_o` is high only while some bit is pending.
- R5: A mask write with `wr_data_i[7]`=1 sets the mask bits selected by `wr_data_i[NUM_SRC-1:0]`. A write with bit 7 = 0 clears the selected bits. Unselected bits keep their value.
- R6: A mask write reaches the shadow mask at the sampling edge and the active mask at the following edge. If the newly enabled bit is already pending, `irq_o` rises after the third edge, counting the write edge as the first, and it rises exactly once.
- R7: The edge that closes a status-read cycle clears all pending bits and drops `irq_o`. Pulses from sources other than Timer B that arrive in that same cycle stay pending. Such a pulse raises `irq_o` again if its bit is enabled.
- R8: A Timer B pulse (index TB_IDX) in a status-read cycle is discarded. A Timer B pulse in the cycle just before the read is pending and is returned by that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_SRC | Event pulses, one per source |
| rd_stat_i | input | 1 | Status read strobe (read clears) |
| wr_mask_i | input | 1 | Mask write strobe |
| wr_data_i | input | 8 | Mask write data, bit 7 selects set or clear |
| rd_data_o | output | 8 | Status word |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block at its default size: five sources, with Timer B at index 1. At this size, all 32 mask values can be crossed with all 32 event patterns. Each combination checks the IRQ level one cycle after the pulse, the returned status word and the clear that follows.

Directed sequences cover the rest:
- the shadow-stage latency of a mask write against an already pending bit;
- clear-mode mask writes;
- a Timer B pulse landing in the read cycle and in the cycle before it;
- non-Timer-B pulses that coincide with a read.

// File: rtl/icr_pkg.sv
package icr_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned MODE_BIT = REG_W - 1;

  // Apply a set/clear mask write to an 8-bit mask image.
  function automatic logic [REG_W-1:0] mask_update(input logic [REG_W-1:0] cur,
                                                   input logic [REG_W-1:0] wdata);
    logic [REG_W-1:0] sel;
    sel = {1'b0, wdata[MODE_BIT-1:0]};
    return wdata[MODE_BIT] ? (cur | sel) : (cur & ~sel);
  endfunction

  // Build the status word from pending bits (zero-extended) and the IRQ level.
  function automatic logic [REG_W-1:0] status_word(input logic [REG_W-1:0] pend_z,
                                                   input logic irq);
    return {irq, pend_z[MODE_BIT-1:0]};
  endfunction
endpackage

// File: rtl/icr_pend.sv
module icr_pend #(
  parameter int unsigned NUM_SRC = 5,
  parameter int unsigned TB_IDX  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               rd_i,
  output logic [NUM_SRC-1:0] keep_o,
  output logic [NUM_SRC-1:0] pend_o
);
  localparam logic [NUM_SRC-1:0] TB_ONEHOT = NUM_SRC'(1) << TB_IDX;

  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] drop_mask;

  // Only a Timer B pulse that meets the read cycle itself is lost.
  assign drop_mask = rd_i ? TB_ONEHOT : '0;
  assign keep_o    = evt_i & ~drop_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (rd_i ? '0 : pend_q) | keep_o;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/icr_mask.sv
module icr_mask #(
  parameter int unsigned NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic [7:0]         wdata_i,
  output logic [NUM_SRC-1:0] shadow_o,
  output logic [NUM_SRC-1:0] active_o
);
  import icr_pkg::*;

  logic [NUM_SRC-1:0] shadow_q;
  logic [NUM_SRC-1:0] active_q;
  logic [REG_W-1:0]   shadow_img;
  logic [REG_W-1:0]   shadow_upd;

  assign shadow_img = REG_W'(shadow_q);
  assign shadow_upd = mask_update(shadow_img, wdata_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (wr_i) shadow_q <= shadow_upd[NUM_SRC-1:0];
      active_q <= shadow_q;
    end
  end

  assign shadow_o = shadow_q;
  assign active_o = active_q;
endmodule

// File: rtl/icr_irq_stage.sv
module icr_irq_stage #(
  parameter int unsigned NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_i,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] keep_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic               irq_o
);
  logic irq_q;
  logic hit_new;
  logic hit_all;

  // Single request path: only the active mask is consulted.
  assign hit_new = |(keep_i & mask_i);
  assign hit_all = |((pend_i | keep_i) & mask_i);

  always_ff @(posedge clk) begin
    if (!rst_n)    irq_q <= 1'b0;
    else if (rd_i) irq_q <= hit_new;
    else           irq_q <= irq_q | hit_all;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/icr_irq_ctrl.sv
module icr_irq_ctrl #(
  parameter int unsigned NUM_SRC = 5,
  parameter int unsigned TB_IDX  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               rd_stat_i,
  input  logic               wr_mask_i,
  input  logic [7:0]         wr_data_i,
  output logic [7:0]         rd_data_o,
  output logic               irq_o
);
  import icr_pkg::*;

  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] evt_keep;
  logic [NUM_SRC-1:0] mask_shadow;
  logic [NUM_SRC-1:0] mask_act;
  logic               irq_q;

  icr_pend #(.NUM_SRC(NUM_SRC), .TB_IDX(TB_IDX)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rd_i(rd_stat_i),
    .keep_o(evt_keep), .pend_o(pend_q)
  );

  icr_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_mask_i), .wdata_i(wr_data_i),
    .shadow_o(mask_shadow), .active_o(mask_act)
  );

  icr_irq_stage #(.NUM_SRC(NUM_SRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .rd_i(rd_stat_i), .pend_i(pend_q),
    .keep_i(evt_keep), .mask_i(mask_act), .irq_o(irq_q)
  );

  assign rd_data_o = status_word(REG_W'(pend_q), irq_q);
  assign irq_o     = irq_q;
endmodule

// File: rtl/icr_irq_ctrl_chk.sv
module icr_irq_ctrl_chk #(
  parameter int unsigned NUM_SRC = 5,
  parameter int unsigned TB_IDX  = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               rd_stat_i,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [NUM_SRC-1:0] mask_shadow,
  input logic [NUM_SRC-1:0] mask_act,
  input logic               irq_o
);
  // R3
  evt_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stat_i && (|(evt_i & mask_act))) |=> irq_o);
  // R4
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !rd_stat_i) |=> irq_o);
  // R4
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_q != '0));
  // R6
  shadow_to_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (mask_act == $past(mask_shadow)));
  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat_i && evt_i == '0) |=> (pend_q == '0 && !irq_o));
  // R8
  tb_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat_i && evt_i[TB_IDX]) |=> !pend_q[TB_IDX]);
endmodule

bind icr_irq_ctrl icr_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .TB_IDX(TB_IDX)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rd_stat_i(rd_stat_i),
  .pend_q(pend_q), .mask_shadow(mask_shadow), .mask_act(mask_act), .irq_o(irq_o)
);

// File: tb/test_icr_irq_ctrl.sv
module test_icr_irq_ctrl;
  localparam int N  = 5;
  localparam int TB = 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] evt = '0;
  logic         rd = 1'b0;
  logic         wr = 1'b0;
  logic [7:0]   wdata = '0;
  logic [7:0]   rdata;
  logic         irq;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  icr_irq_ctrl #(.NUM_SRC(N), .TB_IDX(TB)) i_icr_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .rd_stat_i(rd),
    .wr_mask_i(wr), .wr_data_i(wdata), .rd_data_o(rdata), .irq_o(irq)
  );

  function automatic logic [7:0] exp_word(input logic [N-1:0] p, input logic q);
    logic [7:0] w;
    w = 8'd0;
    for (int b = 0; b < N; b++) w[b] = p[b];
    w[7] = q;
    return w;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, expv);
    end
  endtask

  task automatic step(); @(negedge clk); endtask
  task automatic do_wr(input logic [7:0] d);
    wr = 1'b1; wdata = d; step(); wr = 1'b0;
  endtask
  task automatic do_evt(input logic [N-1:0] e);
    evt = e; step(); evt = '0;
  endtask
  task automatic do_rd(input logic [N-1:0] e, output logic [7:0] seen);
    rd = 1'b1; evt = e; #1 seen = rdata; step(); rd = 1'b0; evt = '0;
  endtask
  task automatic set_mask(input logic [N-1:0] m);
    do_wr(8'h1F); do_wr({3'b100, m}); step();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] seen;
    repeat (3) step();
    rst_n = 1'b1;
    // R1: clean state after reset
    chk("R1 status", rdata, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    do_evt(5'h1F);
    chk("R1 mask zero, no irq", {7'd0, irq}, 8'h00);
    do_rd('0, seen);
    chk("R1 pending after events", seen, exp_word(5'h1F, 1'b0));

    // R2 R3 R5 R7: sweep every mask against every event pattern
    for (int m = 0; m < 32; m++) begin
      set_mask(N'(m));
      for (int e = 0; e < 32; e++) begin
        logic q;
        q = |(N'(m) & N'(e));
        do_evt(N'(e));
        chk("R3 irq one cycle after event", {7'd0, irq}, {7'd0, q});
        do_rd('0, seen);
        chk("R2 status word", seen, exp_word(N'(e), q));
        chk("R7 cleared after read", rdata, 8'h00);
      end
    end

    // R6: mask write against an already pending bit
    set_mask('0);
    do_evt(5'h04);
    chk("R6 masked pending no irq", {7'd0, irq}, 8'h00);
    do_wr(8'h84);
    chk("R6 irq low after write edge", {7'd0, irq}, 8'h00);
    step();
    chk("R6 irq low after second edge", {7'd0, irq}, 8'h00);
    step();
    chk("R6 irq high after third edge", {7'd0, irq}, 8'h01);
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R4 irq held until read", {7'd0, irq}, 8'h01);
    end
    do_wr(8'h04);
    step(); step();
    chk("R4 irq held after mask clear", {7'd0, irq}, 8'h01);
    do_rd('0, seen);
    chk("R4 read shows irq", seen, exp_word(5'h04, 1'b1));

    // R5: clear mode leaves unselected bits alone
    set_mask(5'h1F);
    do_wr(8'h03); step();
    do_evt(5'h01);
    chk("R5 cleared bit masks event", {7'd0, irq}, 8'h00);
    do_evt(5'h04);
    chk("R5 untouched bit still enabled", {7'd0, irq}, 8'h01);
    do_rd('0, seen);

    // R8: Timer B pulse in the read cycle is dropped, others kept
    set_mask('0);
    do_evt(5'h15);
    do_rd(5'h03, seen);
    chk("R8 read returns older bits", seen, exp_word(5'h15, 1'b0));
    do_rd('0, seen);
    chk("R8 TB dropped, other kept", seen, exp_word(5'h01, 1'b0));
    // R8: Timer B pulse one cycle before read is reported
    do_evt(5'h02);
    do_rd('0, seen);
    chk("R8 TB before read kept", seen, exp_word(5'h02, 1'b0));
    // R8: with TB enabled, a coinciding pulse raises no irq
    set_mask(5'h02);
    do_rd(5'h02, seen);
    chk("R8 no irq from dropped TB", {7'd0, irq}, 8'h00);
    // R7: enabled non-TB pulse during read re-raises irq
    set_mask(5'h08);
    do_evt(5'h08);
    do_rd(5'h08, seen);
    chk("R7 coinciding pulse re-raises irq", {7'd0, irq}, 8'h01);
    chk("R7 coinciding pulse pending", rdata, exp_word(5'h08, 1'b1));
    do_rd('0, seen);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule